// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Data Array Write Controller

This block sits between a CPU's external-data bus and a 2048-byte on-chip nonvolatile data array. The array is modelled here as a register array. A control register on the special-function bus picks where external-data accesses go. When the array enable is set, addresses inside the array window go to the on-chip array. When it is clear, or the address is outside the window, the access is forwarded to an off-chip memory bus one cycle later.

Writes to the array are gated by a write-enable bit. An accepted write starts a self-timed cycle whose length, `WR_CYCLES`, is given in clock cycles. The stored byte is committed when that cycle ends. While the cycle runs, a read-only ready bit in the control register reads 0. Any array read during that time returns the byte being written with its top bit inverted. A second array write attempted during the cycle is dropped and sets a sticky error bit, which software clears by writing 1 to it.

Every read, whether from the array or from the off-chip bus, returns on `xd_rdata` with a one-cycle `xd_rvalid` strobe exactly two cycles after the request.

Top module: `eeprom_wcycle_ctrl`

## Requirements
- R1: After a synchronous reset, the control register reads 0x04: array disabled, write disabled, ready set, error clear. No read strobe and no off-chip strobe is active.
- R2: The control register sits at special-function address 0x96, with bit 0 = array enable (RW), bit 1 = write enable (RW), bit 2 = ready (read-only), bit 3 = error (write 1 to clear) and bits 7:4 reading 0. A read returns this word on `sfr_rdata` one cycle later. A read of any other address returns 0x00, and a write to any other address changes nothing.
- R3: An access goes to the array only when the array enable is 1 and the address is below 2048, so 0x7FF is the last array byte. Every other access raises `ext_wr` or `ext_rd` one cycle later, carrying the same address and write data. An array access raises no off-chip strobe.
- R4: Every read request produces `xd_rvalid` for exactly one cycle, two cycles after the request, with the read data on `xd_rdata`.
- R5: An array write made with write enable 1 while ready is 1 clears ready. Ready stays 0 for exactly `WR_CYCLES` cycles and returns to 1 on the following cycle.
- R6: An array read at any address while ready is 0 returns the byte being written with bit 7 inverted.
- R7: After the write cycle ends, array reads of the written address return the written byte unaltered. Other addresses keep their contents.
- R8: An array write made with write enable 0 has no effect: ready stays 1, the error bit stays 0 and the stored byte is unchanged.
- R9: An array write made with write enable 1 while ready is 0 is ignored: the cycle in progress and all stored bytes are unaffected. It sets the error bit, which stays 1 until bit 3 is written as 1.
- R10: Off-chip writes are forwarded regardless of the write-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Special-function bus address |
| sfr_wr | input | 1 | Special-function write strobe |
| sfr_wdata | input | 8 | Special-function write data |
| sfr_rd | input | 1 | Special-function read strobe |
| sfr_rdata | output | 8 | Special-function read data, one cycle after the read |
| xd_addr | input | ADDR_W | External-data address from the CPU |
| xd_wdata | input | DATA_W | External-data write byte |
| xd_wr | input | 1 | External-data write request |
| xd_rd | input | 1 | External-data read request |
| xd_rdata | output | DATA_W | Read data returned to the CPU |
| xd_rvalid | output | 1 | Read data valid, two cycles after the request |
| ext_addr | output | ADDR_W | Off-chip memory address |
| ext_wdata | output | DATA_W | Off-chip write data |
| ext_wr | output | 1 | Off-chip write strobe |
| ext_rd | output | 1 | Off-chip read strobe |
| ext_rdata | input | DATA_W | Off-chip read data, sampled in the cycle `ext_rd` is high |

## Verification
The bench issues a second array write in the very last busy cycle. A design that freed the ready bit one cycle early would accept that write and corrupt a byte the reference model keeps unchanged. It reads a different address from the one being written while busy. A design that applied the inverted-MSB substitute only to a matching address would return stale array data instead. It also writes at the window edges 0x7FF and 0x800 and with write enable cleared. An off-by-one in the window compare would misroute one of those bytes. Gating all writes on write enable would drop the off-chip write. Finally, it clears the error bit while keeping the enables set, which exposes a design that clears the error on any control write.

// File: rtl/eew_pkg.sv
package eew_pkg;
  // Control register bit positions
  localparam int CTL_ARR_EN = 0;
  localparam int CTL_WR_EN  = 1;
  localparam int CTL_READY  = 2;
  localparam int CTL_ERR    = 3;

  // Source of a read in flight
  typedef enum logic [1:0] {
    RT_NONE   = 2'd0,
    RT_ARRAY  = 2'd1,
    RT_SHADOW = 2'd2,
    RT_EXT    = 2'd3
  } route_e;
endpackage

// File: rtl/eew_ctl_reg.sv
module eew_ctl_reg #(
  parameter logic [7:0] SFR_ADDR = 8'h96
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_wdata,
  input  logic       sfr_rd,
  input  logic       busy,
  input  logic       err_set,
  output logic       arr_en,
  output logic       wr_en,
  output logic       err_q,
  output logic [7:0] sfr_rdata
);
  import eew_pkg::*;

  logic       hit;
  logic [7:0] word;
  logic       unused_wbits;

  assign hit          = (sfr_addr == SFR_ADDR);
  assign unused_wbits = ^{sfr_wdata[7:4], sfr_wdata[CTL_READY]};

  always_comb begin
    word             = '0;
    word[CTL_ARR_EN] = arr_en;
    word[CTL_WR_EN]  = wr_en;
    word[CTL_READY]  = !busy;
    word[CTL_ERR]    = err_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_en    <= 1'b0;
      wr_en     <= 1'b0;
      err_q     <= 1'b0;
      sfr_rdata <= '0;
    end else begin
      if (hit && sfr_wr) begin
        arr_en <= sfr_wdata[CTL_ARR_EN];
        wr_en  <= sfr_wdata[CTL_WR_EN];
      end
      if (err_set)
        err_q <= 1'b1;
      else if (hit && sfr_wr && sfr_wdata[CTL_ERR])
        err_q <= 1'b0;
      sfr_rdata <= (hit && sfr_rd) ? word : 8'h00;
    end
  end
endmodule

// File: rtl/eew_route.sv
module eew_route #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arr_en,
  input  logic [ADDR_W-1:0] xd_addr,
  input  logic [DATA_W-1:0] xd_wdata,
  input  logic              xd_wr,
  input  logic              xd_rd,
  output logic              arr_sel,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              ext_wr,
  output logic              ext_rd
);
  logic in_range;

  generate
    if (longint'(DEPTH) >= (64'd1 << ADDR_W)) begin : g_full
      assign in_range = 1'b1;
    end else begin : g_part
      assign in_range = (xd_addr < ADDR_W'(DEPTH));
    end
  endgenerate

  assign arr_sel = arr_en && in_range;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_wr    <= 1'b0;
      ext_rd    <= 1'b0;
      ext_addr  <= '0;
      ext_wdata <= '0;
    end else begin
      ext_wr <= xd_wr && !arr_sel;
      ext_rd <= xd_rd && !arr_sel;
      if ((xd_wr || xd_rd) && !arr_sel) begin
        ext_addr  <= xd_addr;
        ext_wdata <= xd_wdata;
      end
    end
  end
endmodule

// File: rtl/eew_wcycle.sv
module eew_wcycle #(
  parameter int WR_CYCLES = 30000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CNT_W = (WR_CYCLES < 2) ? 1 : $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign last = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= CNT_W'(WR_CYCLES - 1);
    end else if (busy) begin
      if (cnt_q == '0)
        busy <= 1'b0;
      else
        cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/eew_array.sv
module eew_array #(
  parameter int AW     = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DATA_W-1:0] mem [0:WORDS-1];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eeprom_wcycle_ctrl.sv
module eeprom_wcycle_ctrl #(
  parameter int         ADDR_W    = 16,
  parameter int         DATA_W    = 8,
  parameter int         DEPTH     = 2048,
  parameter int         WR_CYCLES = 30000,
  parameter logic [7:0] SFR_ADDR  = 8'h96
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        sfr_addr,
  input  logic              sfr_wr,
  input  logic [7:0]        sfr_wdata,
  input  logic              sfr_rd,
  output logic [7:0]        sfr_rdata,
  input  logic [ADDR_W-1:0] xd_addr,
  input  logic [DATA_W-1:0] xd_wdata,
  input  logic              xd_wr,
  input  logic              xd_rd,
  output logic [DATA_W-1:0] xd_rdata,
  output logic              xd_rvalid,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              ext_wr,
  output logic              ext_rd,
  input  logic [DATA_W-1:0] ext_rdata
);
  import eew_pkg::*;

  localparam int AW = $clog2(DEPTH);

  logic              arr_en, wr_en, err_q;
  logic              busy, last, arr_sel;
  logic              start, err_set;
  logic [AW-1:0]     wa_q;
  logic [DATA_W-1:0] wd_q, ram_q, shadow;
  route_e            src1_q;

  eew_ctl_reg #(.SFR_ADDR(SFR_ADDR)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .sfr_addr (sfr_addr),
    .sfr_wr   (sfr_wr),
    .sfr_wdata(sfr_wdata),
    .sfr_rd   (sfr_rd),
    .busy     (busy),
    .err_set  (err_set),
    .arr_en   (arr_en),
    .wr_en    (wr_en),
    .err_q    (err_q),
    .sfr_rdata(sfr_rdata)
  );

  eew_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_route (
    .clk      (clk),
    .rst      (rst),
    .arr_en   (arr_en),
    .xd_addr  (xd_addr),
    .xd_wdata (xd_wdata),
    .xd_wr    (xd_wr),
    .xd_rd    (xd_rd),
    .arr_sel  (arr_sel),
    .ext_addr (ext_addr),
    .ext_wdata(ext_wdata),
    .ext_wr   (ext_wr),
    .ext_rd   (ext_rd)
  );

  // Array write gating: accepted only when enabled and idle
  assign start   = xd_wr && arr_sel && wr_en && !busy;
  assign err_set = xd_wr && arr_sel && wr_en && busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      wa_q <= '0;
      wd_q <= '0;
    end else if (start) begin
      wa_q <= xd_addr[AW-1:0];
      wd_q <= xd_wdata;
    end
  end

  eew_wcycle #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .busy (busy),
    .last (last)
  );

  // Commit happens at the edge that ends the timed cycle
  eew_array #(.AW(AW), .DATA_W(DATA_W)) u_arr (
    .clk  (clk),
    .we   (last),
    .waddr(wa_q),
    .wdata(wd_q),
    .raddr(xd_addr[AW-1:0]),
    .rdata(ram_q)
  );

  assign shadow = {~wd_q[DATA_W-1], wd_q[DATA_W-2:0]};

  // Two-stage read return: stage 1 records the source, stage 2 muxes
  always_ff @(posedge clk) begin
    if (rst) begin
      src1_q    <= RT_NONE;
      xd_rvalid <= 1'b0;
      xd_rdata  <= '0;
    end else begin
      if (!xd_rd)
        src1_q <= RT_NONE;
      else if (!arr_sel)
        src1_q <= RT_EXT;
      else if (busy)
        src1_q <= RT_SHADOW;
      else
        src1_q <= RT_ARRAY;
      xd_rvalid <= (src1_q != RT_NONE);
      unique case (src1_q)
        RT_ARRAY:  xd_rdata <= ram_q;
        RT_SHADOW: xd_rdata <= shadow;
        RT_EXT:    xd_rdata <= ext_rdata;
        default:   xd_rdata <= xd_rdata;
      endcase
    end
  end
endmodule

// File: rtl/eew_checker.sv
module eew_checker #(
  parameter int         WR_CYCLES = 30000,
  parameter logic [7:0] SFR_ADDR  = 8'h96
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] sfr_addr,
  input logic       sfr_wr,
  input logic       clr_bit,
  input logic       sfr_rd,
  input logic [7:0] sfr_rdata,
  input logic       xd_wr,
  input logic       xd_rd,
  input logic       xd_rvalid,
  input logic       ext_wr,
  input logic       ext_rd,
  input logic       busy,
  input logic       err_q
);
  int unsigned run_q;

  always_ff @(posedge clk) begin
    if (rst)       run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_q == WR_CYCLES); // R5
  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(xd_wr)); // R5
  AST_RVALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    xd_rd |-> ##2 xd_rvalid); // R4
  AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
    xd_rvalid |-> $past(xd_rd, 2)); // R4
  AST_EXT_WR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ext_wr |-> $past(xd_wr)); // R3
  AST_EXT_RD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ext_rd |-> $past(xd_rd)); // R3
  AST_SFR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (sfr_rdata != 8'h00) |-> $past(sfr_rd && sfr_addr == SFR_ADDR)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q && !(sfr_wr && sfr_addr == SFR_ADDR && clr_bit) |=> err_q); // R9
endmodule

bind eeprom_wcycle_ctrl eew_checker #(.WR_CYCLES(WR_CYCLES), .SFR_ADDR(SFR_ADDR)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sfr_addr (sfr_addr),
  .sfr_wr   (sfr_wr),
  .clr_bit  (sfr_wdata[3]),
  .sfr_rd   (sfr_rd),
  .sfr_rdata(sfr_rdata),
  .xd_wr    (xd_wr),
  .xd_rd    (xd_rd),
  .xd_rvalid(xd_rvalid),
  .ext_wr   (ext_wr),
  .ext_rd   (ext_rd),
  .busy     (busy),
  .err_q    (err_q)
);

// File: tb/eeprom_wcycle_ctrl_test.sv
module eeprom_wcycle_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WRC        = 20;
  localparam logic [7:0] CTL = 8'h96;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
  logic        sfr_wr, sfr_rd;
  logic [15:0] xd_addr, ext_addr;
  logic [7:0]  xd_wdata, xd_rdata, ext_wdata, ext_rdata;
  logic        xd_wr, xd_rd, xd_rvalid, ext_wr, ext_rd;

  int    tests = 0;
  int    fails = 0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_wcycle_ctrl #(.WR_CYCLES(WRC)) uut (
    .clk(clk), .rst(rst),
    .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
    .sfr_rd(sfr_rd), .sfr_rdata(sfr_rdata),
    .xd_addr(xd_addr), .xd_wdata(xd_wdata), .xd_wr(xd_wr), .xd_rd(xd_rd),
    .xd_rdata(xd_rdata), .xd_rvalid(xd_rvalid),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_wr(ext_wr),
    .ext_rd(ext_rd), .ext_rdata(ext_rdata)
  );

  // Off-chip memory device
  logic [7:0] xdev [0:255];
  assign ext_rdata = xdev[ext_addr[7:0]];
  always @(posedge clk) if (ext_wr) xdev[ext_addr[7:0]] <= ext_wdata;

  // Behavioural reference model
  logic [7:0]  mmem [0:2047];
  logic [7:0]  xm   [0:255];
  bit          m_ae, m_we, m_err;
  int          m_busy;
  logic [10:0] m_wa;
  logic [7:0]  m_wd;
  bit          p1_v;
  logic [7:0]  p1_d;
  bit          e_rvalid, e_ext_wr, e_ext_rd;
  logic [7:0]  e_rdata, e_sfr, e_ext_wd;
  logic [15:0] e_ext_addr;
  bit          wb, hb, onb, setb;

  always @(posedge clk) begin
    if (rst) begin
      m_ae = 0; m_we = 0; m_err = 0; m_busy = 0; p1_v = 0;
      e_rvalid = 0; e_sfr = 8'h00; e_ext_wr = 0; e_ext_rd = 0;
    end else begin
      wb  = (m_busy != 0);
      hb  = (sfr_addr == CTL);
      onb = m_ae && (xd_addr < 16'd2048);
      e_rvalid = p1_v;
      e_rdata  = p1_d;
      p1_v = xd_rd;
      if (xd_rd)
        p1_d = onb ? (wb ? {~m_wd[7], m_wd[6:0]} : mmem[xd_addr[10:0]])
                   : xm[xd_addr[7:0]];
      e_sfr = (sfr_rd && hb) ? {4'b0, m_err, !wb, m_we, m_ae} : 8'h00;
      e_ext_wr = xd_wr && !onb;
      e_ext_rd = xd_rd && !onb;
      if ((xd_wr || xd_rd) && !onb) begin
        e_ext_addr = xd_addr;
        e_ext_wd   = xd_wdata;
      end
      if (xd_wr && !onb) xm[xd_addr[7:0]] = xd_wdata;
      setb = xd_wr && onb && m_we && wb;
      if (wb) begin
        m_busy = m_busy - 1;
        if (m_busy == 0) mmem[m_wa] = m_wd;
      end
      if (xd_wr && onb && m_we && !wb) begin
        m_busy = WRC; m_wa = xd_addr[10:0]; m_wd = xd_wdata;
      end
      if (setb) m_err = 1;
      else if (sfr_wr && hb && sfr_wdata[3]) m_err = 0;
      if (sfr_wr && hb) begin
        m_ae = sfr_wdata[0];
        m_we = sfr_wdata[1];
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(xd_rvalid === e_rvalid, "xd_rvalid (R4)", 32'(xd_rvalid), 32'(e_rvalid));
      if (e_rvalid) chk(xd_rdata === e_rdata, "xd_rdata", 32'(xd_rdata), 32'(e_rdata));
      chk(sfr_rdata === e_sfr, "sfr_rdata (R2)", 32'(sfr_rdata), 32'(e_sfr));
      chk(ext_wr === e_ext_wr, "ext_wr (R3)", 32'(ext_wr), 32'(e_ext_wr));
      chk(ext_rd === e_ext_rd, "ext_rd (R3)", 32'(ext_rd), 32'(e_ext_rd));
      if (e_ext_wr || e_ext_rd) chk(ext_addr === e_ext_addr, "ext_addr (R3)", 32'(ext_addr), 32'(e_ext_addr));
      if (e_ext_wr) chk(ext_wdata === e_ext_wd, "ext_wdata (R3)", 32'(ext_wdata), 32'(e_ext_wd));
    end
  end

  // Stimulus tasks: called at a falling edge, return one falling edge later
  task automatic sfr_w(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic sfr_r(input logic [7:0] a);
    sfr_addr = a; sfr_rd = 1'b1;
    @(negedge clk);
    sfr_rd = 1'b0;
  endtask

  task automatic poll(input int n);
    sfr_addr = CTL; sfr_rd = 1'b1;
    repeat (n) @(negedge clk);
    sfr_rd = 1'b0;
  endtask

  task automatic xd_w(input logic [15:0] a, input logic [7:0] d);
    xd_addr = a; xd_wdata = d; xd_wr = 1'b1;
    @(negedge clk);
    xd_wr = 1'b0;
  endtask

  task automatic xd_r(input logic [15:0] a);
    xd_addr = a; xd_rd = 1'b1;
    @(negedge clk);
    xd_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin xm[i] = 8'h00; xdev[i] = 8'h00; end
    for (int i = 0; i < 2048; i++) mmem[i] = 8'h00;
    rst = 1'b1;
    sfr_addr = 8'h00; sfr_wdata = 8'h00; sfr_wr = 1'b0; sfr_rd = 1'b0;
    xd_addr = 16'h0; xd_wdata = 8'h00; xd_wr = 1'b0; xd_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    cur_tag = "R1";
    sfr_r(CTL);
    chk(sfr_rdata === 8'h04, "reset status", 32'(sfr_rdata), 32'h04);
    chk(xd_rvalid === 1'b0 && ext_wr === 1'b0, "idle strobes", 32'({xd_rvalid, ext_wr}), 32'h0);

    // R2: address decode and field layout
    cur_tag = "R2";
    sfr_r(8'h55);
    chk(sfr_rdata === 8'h00, "foreign address read", 32'(sfr_rdata), 32'h00);
    sfr_w(CTL, 8'h03);
    sfr_r(CTL);
    chk(sfr_rdata === 8'h07, "enables set", 32'(sfr_rdata), 32'h07);
    sfr_w(8'h97, 8'h00);
    sfr_r(CTL);
    chk(sfr_rdata === 8'h07, "foreign write ignored", 32'(sfr_rdata), 32'h07);

    // R5: ready timing polled every cycle; seed array contents
    cur_tag = "R5";
    xd_w(16'h0010, 8'h5A);
    poll(WRC + 2);
    xd_w(16'h0020, 8'hC3);
    idle(WRC + 2);
    xd_w(16'h07FF, 8'h81);   // last array byte
    poll(WRC + 2);

    // R7: committed bytes read back true
    cur_tag = "R7";
    xd_r(16'h0010);
    xd_r(16'h0020);
    xd_r(16'h07FF);
    idle(2);

    // R3: array disabled routes everything off-chip
    cur_tag = "R3";
    sfr_w(CTL, 8'h00);
    xd_w(16'h0010, 8'hA5);
    xd_r(16'h0010);
    idle(2);

    // R10: off-chip write with write enable clear; R3 boundary 0x800
    cur_tag = "R10";
    sfr_w(CTL, 8'h01);
    xd_w(16'h0800, 8'h3C);
    xd_r(16'h0800);
    idle(2);

    // R8: array write with write enable clear has no effect
    cur_tag = "R8";
    xd_w(16'h0010, 8'h11);
    sfr_r(CTL);
    chk(sfr_rdata === 8'h05, "status after gated write", 32'(sfr_rdata), 32'h05);
    xd_r(16'h0010);
    idle(2);

    // R6: reads during busy return the shadow byte, any address
    cur_tag = "R6";
    sfr_w(CTL, 8'h03);
    xd_w(16'h0010, 8'h77);
    xd_r(16'h0010);
    xd_r(16'h0020);
    idle(1);
    chk(xd_rdata === 8'hF7, "shadow byte", 32'(xd_rdata), 32'hF7);

    // R9: write while busy ignored, error sticky
    cur_tag = "R9";
    xd_w(16'h0020, 8'h99);
    sfr_r(CTL);
    chk(sfr_rdata === 8'h0B, "busy with error", 32'(sfr_rdata), 32'h0B);
    idle(WRC);
    cur_tag = "R7";
    xd_r(16'h0010);
    xd_r(16'h0020);
    idle(2);
    cur_tag = "R9";
    sfr_r(CTL);
    chk(sfr_rdata === 8'h0F, "error held after cycle", 32'(sfr_rdata), 32'h0F);
    sfr_w(CTL, 8'h0B);
    sfr_r(CTL);
    chk(sfr_rdata === 8'h07, "error cleared", 32'(sfr_rdata), 32'h07);

    // R9: write landing in the final busy cycle is rejected
    xd_w(16'h07FF, 8'h42);
    idle(WRC - 1);
    xd_w(16'h0020, 8'h55);
    poll(3);
    xd_r(16'h0020);
    xd_r(16'h07FF);
    idle(2);
    chk(xd_rdata === 8'h42, "final byte committed", 32'(xd_rdata), 32'h42);

    // R5: write right after ready returns is accepted
    cur_tag = "R5";
    sfr_w(CTL, 8'h0B);
    xd_w(16'h0020, 8'h55);
    poll(WRC + 2);
    cur_tag = "R7";
    xd_r(16'h0020);
    idle(2);
    chk(xd_rdata === 8'h55, "second write committed", 32'(xd_rdata), 32'h55);

    idle(2);
    finish_run();
  end
endmodule